// File: doc/BRIEF.md
# Asynchronous I/O Register Slave Front End

This block sits between a 32-bit expansion bus and a small set of peripheral registers. Bus timing is set by an active-low address strobe followed by separate active-low read and write strobes. The block tracks the address strobe to hold a word address, four byte-lane enables and an address-enable qualifier for the rest of the access. It checks whether the held address falls inside a 16-byte I/O window set by a parameter. Inside that window it turns the read and write strobes into register selects. Write data is merged into the target register one byte lane at a time. Read data is driven for as long as the read strobe is held.

All bus strobes are brought into the internal clock domain through two-flop synchronisers. A write takes effect on the detected release of the write strobe. Every bus access is long compared with the clock, so the block never asks the bus to wait. The demo register file has two general registers, an event register and an interrupt mask. Event bits are set by internal event pulses. Writing ones to the event register clears those bits. A one-clock active-high interrupt pulse marks each unmasked event bit that becomes newly set, which makes the pulse suitable for an edge-triggered interrupt input.

Top module: `io_slave_front`

## Requirements
- R1: After reset all registers and event bits read as zero, `irq` is low, `rdDrive` is low and `rdData` is zero.
- R2: `busAddr` and `beN` are followed while the address strobe is low and are held once it returns high. Changes to these inputs after the strobe has closed do not affect the access.
- R3: `aenIn` is followed while the address strobe is low and is held once the strobe closes. If the held qualifier is high, the access is a miss: no register changes and `rdDrive` stays low.
- R4: An access hits only when held address bits 15:4 equal bits 15:4 of `BASE_ADDR`. Held bits 3:2 select register 0 to 3. An access outside the window changes no register.
- R5: A hitting write commits once, at the synchronised rising edge of `wrN`. It updates only the byte lanes whose `beN` bit was low, where bit n covers data bits 8n+7:8n. Registers 0, 1 and 3 store all 32 bits.
- R6: While a hitting read strobe is held (after the two-flop delay), `rdDrive` is high and `rdData` shows the selected register. Otherwise `rdDrive` is low and `rdData` is zero.
- R7: Register 2 holds `EVT_W` event bits, zero-extended on read. A high `eventIn` bit sets the matching event bit. Writing a one on an enabled lane clears that bit, and writing a zero leaves it unchanged.
- R8: `irq` pulses high for exactly one clock, in the cycle after an `eventIn` bit rises on an event bit that is clear and whose mask bit is set. The mask is the low `EVT_W` bits of register 3. An event that is masked or already set gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 14 | Word address, bus bits 15:2 |
| aenIn | input | 1 | Active-low address-enable qualifier |
| adsN | input | 1 | Active-low address strobe |
| beN | input | 4 | Active-low byte-lane enables |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| wrData | input | 32 | Write data from the bus |
| rdData | output | 32 | Read data, zero when not driven |
| rdDrive | output | 1 | High while read data is driven onto the bus |
| eventIn | input | 8 | Internal event pulses, one per event bit |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
Errors in the held address, byte enables or qualifier show up as wrong read-back values or as writes that land in the wrong lane or register. The bench sweeps every register offset against all sixteen byte-enable patterns, then reads each result back within the same access sequence. A wrong decode also shows on `rdDrive` during the next read strobe, about two clocks after the strobe falls. Wrong event or mask state shows as a missing or extra `irq` pulse in the clock after the event input, and as a wrong value when register 2 is read.

// File: rtl/io_slave_pkg.sv
package io_slave_pkg;

  // Strobes handed from the control to the datapath, all in the clock domain.
  typedef struct packed {
    logic adsOpen;   // synchronised address strobe is low
    logic wrOpen;    // synchronised write strobe is low
    logic wrRise;    // one-cycle pulse on write-strobe release
    logic rdActive;  // synchronised read strobe is low
  } strobeBus_t;

endpackage

// File: rtl/io_slave_ctrl.sv
module io_slave_ctrl
  import io_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       adsN,
  input  logic       rdN,
  input  logic       wrN,
  output strobeBus_t strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] adsSync;
  logic [LAST:0] rdSync;
  logic [LAST:0] wrSync;
  logic          wrPrev;

  // Idle level of every strobe is high, so the synchronisers reset high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adsSync <= '1;
      rdSync  <= '1;
      wrSync  <= '1;
      wrPrev  <= 1'b1;
    end else begin
      adsSync <= {adsSync[LAST-1:0], adsN};
      rdSync  <= {rdSync[LAST-1:0], rdN};
      wrSync  <= {wrSync[LAST-1:0], wrN};
      wrPrev  <= wrSync[LAST];
    end
  end

  always_comb begin
    strb.adsOpen  = !adsSync[LAST];
    strb.wrOpen   = !wrSync[LAST];
    strb.rdActive = !rdSync[LAST];
    strb.wrRise   = wrSync[LAST] && !wrPrev;
  end

  // One release of the write strobe yields a single commit pulse.
  assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRise |=> !strb.wrRise);

endmodule

// File: rtl/io_slave_dp.sv
module io_slave_dp
  import io_slave_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          LANES     = 4,
  parameter int          EVT_W     = 8,
  parameter logic [15:0] BASE_ADDR = 16'h0300
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeBus_t          strb,
  input  logic [ADDR_W-1:2]   busAddr,
  input  logic                aenIn,
  input  logic [LANES-1:0]    beN,
  input  logic [8*LANES-1:0]  wrData,
  input  logic [EVT_W-1:0]    eventIn,
  output logic [8*LANES-1:0]  rdData,
  output logic                rdDrive,
  output logic                irq
);

  localparam int DATA_W  = 8 * LANES;
  localparam int NUM_REG = 4;
  localparam int EVT_IDX = 2;
  localparam int MSK_IDX = 3;

  logic [ADDR_W-1:2] addrQ;
  logic [LANES-1:0]  beQ;
  logic              aenQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] regFile [NUM_REG];
  logic [EVT_W-1:0]  evtBits;
  logic [DATA_W-1:0] laneMask;
  logic [1:0]        regSel;
  logic              hit;
  logic              wrCommit;
  logic [EVT_W-1:0]  evtClear;
  logic [EVT_W-1:0]  evtMask;
  logic [DATA_W-1:0] selData;

  // Address phase: follow the bus while the strobe is low, hold afterwards.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      beQ   <= '1;
      aenQ  <= 1'b1;
    end else if (strb.adsOpen) begin
      addrQ <= busAddr;
      beQ   <= beN;
      aenQ  <= aenIn;
    end
  end

  // Write data follows the bus while the write strobe is low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wrDataQ <= '0;
    else if (strb.wrOpen) wrDataQ <= wrData;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) laneMask[8*l +: 8] = {8{!beQ[l]}};
  end

  assign regSel   = addrQ[3:2];
  assign hit      = !aenQ && (addrQ[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign wrCommit = strb.wrRise && hit;
  assign evtClear = (wrCommit && regSel == 2'(EVT_IDX)) ? (wrDataQ[EVT_W-1:0] & laneMask[EVT_W-1:0]) : '0;
  assign evtMask  = regFile[MSK_IDX][EVT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REG; r++) regFile[r] <= '0;
    end else if (wrCommit && regSel != 2'(EVT_IDX)) begin
      regFile[regSel] <= (regFile[regSel] & ~laneMask) | (wrDataQ & laneMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtBits <= '0;
      irq     <= 1'b0;
    end else begin
      evtBits <= (evtBits | eventIn) & ~evtClear;
      irq     <= |(eventIn & ~evtBits & evtMask);
    end
  end

  always_comb begin
    if (regSel == 2'(EVT_IDX)) selData = {{(DATA_W-EVT_W){1'b0}}, evtBits};
    else                       selData = regFile[regSel];
  end

  assign rdDrive = strb.rdActive && hit;
  assign rdData  = rdDrive ? selData : '0;

  // Held address does not move once the strobe has closed.
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.adsOpen && !$past(strb.adsOpen)) |-> $stable(addrQ) && $stable(beQ) && $stable(aenQ));

  // A general register changes only on a committing write.
  assert_reg_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !wrCommit |=> $stable(regFile[0]) && $stable(regFile[1]) && $stable(regFile[MSK_IDX]));

  // Event bits are sticky until a committing write clears them.
  assert_event_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrCommit |=> ((evtBits & $past(evtBits)) == $past(evtBits)));

  // Interrupt pulses only follow an unmasked event input.
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(|(eventIn & evtMask)));

  // Data is driven only for a qualified access.
  assert_drive_qualified_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdDrive |-> !aenQ);

endmodule

// File: rtl/io_slave_front.sv
module io_slave_front
  import io_slave_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0300,
  parameter int          EVT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [13:0]       busAddr,
  input  logic              aenIn,
  input  logic              adsN,
  input  logic [3:0]        beN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rdDrive,
  input  logic [EVT_W-1:0]  eventIn,
  output logic              irq
);

  strobeBus_t strb;

  io_slave_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .adsN (adsN),
    .rdN  (rdN),
    .wrN  (wrN),
    .strb (strb)
  );

  io_slave_dp #(
    .ADDR_W    (16),
    .LANES     (4),
    .EVT_W     (EVT_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busAddr (busAddr),
    .aenIn   (aenIn),
    .beN     (beN),
    .wrData  (wrData),
    .eventIn (eventIn),
    .rdData  (rdData),
    .rdDrive (rdDrive),
    .irq     (irq)
  );

endmodule

// File: tb/io_slave_front_bench.sv
module io_slave_front_bench;

  localparam logic [15:0] BASE = 16'h0300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] busAddr = '0;
  logic        aenIn = 1'b1;
  logic        adsN = 1'b1;
  logic [3:0]  beN = 4'hF;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdDrive;
  logic [7:0]  eventIn = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;

  logic [31:0] regM [4];
  logic [7:0]  evtM = '0;

  always #2 clk = ~clk;

  io_slave_front #(.BASE_ADDR(BASE), .EVT_W(8)) u_io_slave_front (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .aenIn(aenIn), .adsN(adsN),
    .beN(beN), .rdN(rdN), .wrN(wrN), .wrData(wrData), .rdData(rdData),
    .rdDrive(rdDrive), .eventIn(eventIn), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] laneBits(input logic [3:0] b);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{!b[l]}};
    return m;
  endfunction

  // One bus access. Address-phase inputs are scrambled after the strobe closes.
  task automatic access(input logic [15:0] a, input logic [3:0] be, input logic aen,
                        input logic doWrite, input logic [31:0] d,
                        output logic [31:0] rd, output logic drv);
    @(negedge clk);
    busAddr = a[15:2]; beN = be; aenIn = aen; adsN = 1'b0;
    repeat (4) @(negedge clk);
    adsN = 1'b1;
    repeat (3) @(negedge clk);
    busAddr = ~a[15:2]; beN = ~be; aenIn = ~aen;
    if (doWrite) begin wrData = d; wrN = 1'b0; end
    else rdN = 1'b0;
    repeat (4) @(negedge clk);
    rd = rdData; drv = rdDrive;
    wrN = 1'b1; rdN = 1'b1;
    repeat (4) @(negedge clk);
    wrData = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
  endtask

  task automatic modelWrite(input int off, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] m;
    m = laneBits(be);
    if (off == 2) evtM = evtM & ~(d[7:0] & m[7:0]);
    else regM[off] = (regM[off] & ~m) | (d & m);
  endtask

  function automatic logic [31:0] modelRead(input int off);
    return (off == 2) ? {24'h0, evtM} : regM[off];
  endfunction

  task automatic pulseEvent(input logic [7:0] ev, output int pulses);
    pulses = 0;
    @(negedge clk);
    eventIn = ev;
    @(negedge clk);
    eventIn = '0;
    if (irq) pulses++;
    repeat (3) begin
      @(negedge clk);
      if (irq) pulses++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic drv;
    int pulses;
    for (int i = 0; i < 4; i++) regM[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rdDrive", {31'h0, rdDrive}, 32'h0);
    check("R1 rdData", rdData, 32'h0);
    for (int off = 0; off < 4; off++) begin
      access(BASE + 16'(off*4), 4'h0, 1'b0, 1'b0, '0, rd, drv);
      check("R1 reg", rd, 32'h0);
    end

    // R2 R5 R6: every offset against every byte-enable pattern
    for (int off = 0; off < 4; off++) begin
      for (int be = 0; be < 16; be++) begin
        logic [31:0] d;
        d = 32'h9E37_79B9 * (32'(off) * 16 + 32'(be) + 1);
        access(BASE + 16'(off*4), 4'(be), 1'b0, 1'b1, d, rd, drv);
        modelWrite(off, 4'(be), d);
        access(BASE + 16'(off*4), 4'h0, 1'b0, 1'b0, '0, rd, drv);
        check("R5 lane merge", rd, modelRead(off));
        check("R6 drive", {31'h0, drv}, 32'h1);
      end
    end

    // R6: no drive while idle
    check("R6 idle data", rdData, 32'h0);
    check("R6 idle drive", {31'h0, rdDrive}, 32'h0);

    // R4: window miss leaves registers alone and does not drive
    access(BASE + 16'h0010, 4'h0, 1'b0, 1'b1, 32'h1111_2222, rd, drv);
    access(BASE - 16'h0010, 4'h0, 1'b0, 1'b1, 32'h3333_4444, rd, drv);
    access(BASE + 16'h0010, 4'h0, 1'b0, 1'b0, '0, rd, drv);
    check("R4 miss drive", {31'h0, drv}, 32'h0);
    check("R4 miss data", rd, 32'h0);
    access(BASE, 4'h0, 1'b0, 1'b0, '0, rd, drv);
    check("R4 reg0 kept", rd, regM[0]);

    // R3: qualifier high means miss
    access(BASE + 16'h4, 4'h0, 1'b1, 1'b1, 32'h5555_6666, rd, drv);
    access(BASE + 16'h4, 4'h0, 1'b1, 1'b0, '0, rd, drv);
    check("R3 aen miss drive", {31'h0, drv}, 32'h0);
    access(BASE + 16'h4, 4'h0, 1'b0, 1'b0, '0, rd, drv);
    check("R3 reg1 kept", rd, regM[1]);

    // R8 R7: events and interrupt
    access(BASE + 16'hC, 4'h0, 1'b0, 1'b1, 32'h0000_0005, rd, drv);
    modelWrite(3, 4'h0, 32'h0000_0005);
    pulseEvent(8'h01, pulses);
    check("R8 unmasked pulse", 32'(pulses), 32'd1);
    pulseEvent(8'h01, pulses);
    check("R8 already set", 32'(pulses), 32'd0);
    pulseEvent(8'h02, pulses);
    check("R8 masked", 32'(pulses), 32'd0);
    evtM = 8'h03;
    access(BASE + 16'h8, 4'h0, 1'b0, 1'b0, '0, rd, drv);
    check("R7 event read", rd, 32'h0000_0003);
    access(BASE + 16'h8, 4'hE, 1'b0, 1'b1, 32'h0000_0001, rd, drv);
    modelWrite(2, 4'hE, 32'h0000_0001);
    access(BASE + 16'h8, 4'h0, 1'b0, 1'b0, '0, rd, drv);
    check("R7 clear one", rd, 32'h0000_0002);
    access(BASE + 16'h8, 4'hF, 1'b0, 1'b1, 32'h0000_00FF, rd, drv);
    access(BASE + 16'h8, 4'h0, 1'b0, 1'b0, '0, rd, drv);
    check("R7 no lane no clear", rd, 32'h0000_0002);
    pulseEvent(8'h04, pulses);
    check("R8 second source", 32'(pulses), 32'd1);
    pulseEvent(8'h01, pulses);
    check("R8 after clear", 32'(pulses), 32'd1);
    access(BASE + 16'h8, 4'h0, 1'b0, 1'b0, '0, rd, drv);
    check("R7 final bits", rd, 32'h0000_0007);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule